// File: doc/BRIEF.md
# Serial Audio DAC Word Transmitter

The block takes signed PCM samples in parallel form from a sample source and delivers them to a serial-input audio converter over three wires: a bit clock, a data line and an active-low latch strobe. It runs from a fast system clock. The bit clock comes from dividing that system clock, and each phase is long enough to meet the converter's minimum timing. Each word goes out most significant bit first. After the last bit the block waits a guard interval and then drives a timed low pulse on the latch line, which moves the finished word into the converter. Once the latch line is high again, the block accepts the next sample through a valid/ready handshake.

A parameter sets the word length; the converter variants use 16 or 18 bits. Every timing minimum is a parameter counted in system clock cycles: bit-clock high, bit-clock low, bit-clock period, data setup/hold, latch guard and latch pulse width. The block derives its phase lengths from these parameters. When two parameters constrain the same phase, the larger one sets the length, so no single minimum can be violated.

Top module: `dac_word_tx`

## Requirements
- R1: While rst_ni is low, bclk_o is 0, sdata_o is 0, latch_no is 1 and in_ready_o is 1.
- R2: A sample accepted when in_valid_i and in_ready_o are both high at a clock edge is sent as WORD_W bits, starting with bit WORD_W-1 and ending with bit 0. A receiver that shifts sdata_o in on each rising bclk_o edge holds the exact two's-complement sample when latch_no falls. This holds for zero, all ones, and the full-scale positive and full-scale negative codes.
- R3: Each word produces exactly WORD_W rising edges of bclk_o before latch_no falls.
- R4: sdata_o changes only while bclk_o is low. It does not change on the cycle bclk_o rises, nor at any point during the high phase.
- R5: Each bclk_o high phase lasts exactly HI_CYC = max(BCLK_HI_MIN, SETUP_MIN) cycles. Each low phase before a rising edge lasts at least LO_CYC = max(BCLK_LO_MIN, SETUP_MIN, BCLK_PERIOD_MIN - HI_CYC) cycles.
- R6: latch_no falls exactly max(LATCH_GAP_MIN,1) cycles after the last falling edge of bclk_o. bclk_o stays low for as long as latch_no is low.
- R7: Each latch_no low pulse lasts exactly max(LATCH_LOW_MIN,1) cycles.
- R8: in_ready_o is high only while latch_no is high and bclk_o is low. It is high in the same cycle that latch_no returns high after a pulse.
- R9: in_valid_i and in_sample_i have no effect while in_ready_o is low. A different value presented during a transfer does not alter the word being latched.
- R10: in_ready_o goes low in the cycle after an accept. If in_valid_i is held high, the next sample is taken on the first cycle in_ready_o is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample offered |
| in_ready_o | output | 1 | Block idle, sample can be taken |
| in_sample_i | input | WORD_W | Two's-complement sample |
| bclk_o | output | 1 | Bit clock to converter, idles low |
| sdata_o | output | 1 | Serial data, MSB first |
| latch_no | output | 1 | Active-low latch strobe, idles high |

## Verification
The bench builds two copies of the block. The first uses 16-bit words with the default cycle counts for a 250 MHz system clock. In that copy the period minimum stretches the low phase to 12 cycles, and the latch pulse runs 10 cycles. The second uses 18-bit words with tight counts: a guard and a latch pulse of a single cycle, and a setup minimum that lengthens the high phase above its own minimum. This brings the one-cycle counter loads and the precedence between competing minimums within reach. Both copies run the extreme codes, back-to-back words with valid held high, and a sample changed in the middle of a transfer.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_GAP,
    ST_LATCH
  } tx_state_e;

  function automatic int unsigned cyc_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // period minus high phase, floored at one cycle
  function automatic int unsigned cyc_rem(input int unsigned per, input int unsigned hi);
    return (per > hi) ? per - hi : 1;
  endfunction

endpackage

// File: rtl/dac_tx_timer.sv
module dac_tx_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/dac_tx_shreg.sv
module dac_tx_shreg #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              msb_o
);
  logic [WORD_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '0;
    else if (load_i)   sr_q <= word_i;
    else if (shift_i)  sr_q <= {sr_q[WORD_W-2:0], 1'b0};
  end

  assign msb_o = sr_q[WORD_W-1];
endmodule

// File: rtl/dac_tx_ctrl.sv
module dac_tx_ctrl
  import dac_tx_pkg::*;
#(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned HI_CYC  = 8,
  parameter int unsigned LO_CYC  = 12,
  parameter int unsigned GAP_CYC = 4,
  parameter int unsigned LE_CYC  = 10,
  parameter int unsigned CNT_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             expired_i,
  output logic             in_ready_o,
  output logic             load_word_o,
  output logic             shift_o,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             bclk_o,
  output logic             latch_no
);
  localparam int unsigned BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  tx_state_e        state_q, state_d;
  logic [BIT_W-1:0] bit_q;
  logic             bclk_q, le_q;
  logic             last_bit;

  assign last_bit   = (bit_q == LAST_BIT);
  assign in_ready_o = (state_q == ST_IDLE);

  always_comb begin
    state_d     = state_q;
    load_word_o = 1'b0;
    shift_o     = 1'b0;
    tmr_load_o  = 1'b0;
    tmr_val_o   = '0;
    unique case (state_q)
      ST_IDLE: if (in_valid_i) begin
        load_word_o = 1'b1;
        tmr_load_o  = 1'b1;
        tmr_val_o   = CNT_W'(LO_CYC - 1);
        state_d     = ST_LOW;
      end
      ST_LOW: if (expired_i) begin
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(HI_CYC - 1);
        state_d    = ST_HIGH;
      end
      ST_HIGH: if (expired_i) begin
        tmr_load_o = 1'b1;
        if (last_bit) begin
          tmr_val_o = CNT_W'(GAP_CYC - 1);
          state_d   = ST_GAP;
        end else begin
          shift_o   = 1'b1;
          tmr_val_o = CNT_W'(LO_CYC - 1);
          state_d   = ST_LOW;
        end
      end
      ST_GAP: if (expired_i) begin
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(LE_CYC - 1);
        state_d    = ST_LATCH;
      end
      ST_LATCH: if (expired_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      bclk_q  <= 1'b0;
      le_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      if (load_word_o)  bit_q <= '0;
      else if (shift_o) bit_q <= bit_q + 1'b1;
      // registered pins decoded from next state: glitch free
      bclk_q <= (state_d == ST_HIGH);
      le_q   <= (state_d != ST_LATCH);
    end
  end

  assign bclk_o   = bclk_q;
  assign latch_no = le_q;
endmodule

// File: rtl/dac_word_tx.sv
module dac_word_tx
  import dac_tx_pkg::*;
#(
  parameter int unsigned WORD_W          = 16,
  parameter int unsigned BCLK_HI_MIN     = 8,
  parameter int unsigned BCLK_LO_MIN     = 8,
  parameter int unsigned BCLK_PERIOD_MIN = 20,
  parameter int unsigned SETUP_MIN       = 4,
  parameter int unsigned LATCH_GAP_MIN   = 4,
  parameter int unsigned LATCH_LOW_MIN   = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_sample_i,
  output logic              bclk_o,
  output logic              sdata_o,
  output logic              latch_no
);
  // setup minimum doubles as hold minimum across the high phase
  localparam int unsigned HI_CYC  = cyc_max(cyc_max(BCLK_HI_MIN, SETUP_MIN), 1);
  localparam int unsigned LO_CYC  = cyc_max(cyc_max(BCLK_LO_MIN, SETUP_MIN),
                                            cyc_rem(BCLK_PERIOD_MIN, HI_CYC));
  localparam int unsigned GAP_CYC = cyc_max(LATCH_GAP_MIN, 1);
  localparam int unsigned LE_CYC  = cyc_max(LATCH_LOW_MIN, 1);
  localparam int unsigned MAX_CYC = cyc_max(cyc_max(HI_CYC, LO_CYC), cyc_max(GAP_CYC, LE_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic             expired, load_word, shift, tmr_load;
  logic [CNT_W-1:0] tmr_val;

  dac_tx_ctrl #(
    .WORD_W (WORD_W),
    .HI_CYC (HI_CYC),
    .LO_CYC (LO_CYC),
    .GAP_CYC(GAP_CYC),
    .LE_CYC (LE_CYC),
    .CNT_W  (CNT_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .expired_i  (expired),
    .in_ready_o (in_ready_o),
    .load_word_o(load_word),
    .shift_o    (shift),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .bclk_o     (bclk_o),
    .latch_no   (latch_no)
  );

  dac_tx_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .expired_o (expired)
  );

  dac_tx_shreg #(.WORD_W(WORD_W)) u_shreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_word),
    .shift_i(shift),
    .word_i (in_sample_i),
    .msb_o  (sdata_o)
  );
endmodule

// File: rtl/dac_word_tx_chk.sv
module dac_word_tx_chk #(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned HI_CYC  = 8,
  parameter int unsigned LO_CYC  = 12,
  parameter int unsigned GAP_CYC = 4,
  parameter int unsigned LE_CYC  = 10
) (
  input logic clk_i,
  input logic rst_ni,
  input logic in_valid_i,
  input logic in_ready_o,
  input logic bclk_o,
  input logic sdata_o,
  input logic latch_no
);
  logic [15:0] hi_run, lo_run, le_run, rise_cnt;
  logic        bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run <= '0; lo_run <= '0; le_run <= '0; rise_cnt <= '0; bclk_q <= 1'b0;
    end else begin
      bclk_q <= bclk_o;
      hi_run <= bclk_o ? hi_run + 1'b1 : '0;
      if (bclk_o)              lo_run <= '0;
      else if (lo_run != '1)   lo_run <= lo_run + 1'b1;
      le_run <= latch_no ? '0 : le_run + 1'b1;
      if (in_valid_i && in_ready_o)  rise_cnt <= '0;
      else if (bclk_o && !bclk_q)    rise_cnt <= rise_cnt + 1'b1;
    end
  end

  // R4
  data_stable_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclk_o |-> $stable(sdata_o));
  // R5
  bclk_hi_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bclk_o) |-> hi_run == 16'(HI_CYC));
  // R5
  bclk_lo_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bclk_o) |-> lo_run >= 16'(LO_CYC));
  // R3
  rise_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(latch_no) |-> rise_cnt == 16'(WORD_W));
  // R6
  latch_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(latch_no) |-> lo_run == 16'(GAP_CYC));
  // R6
  latch_bclk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_no |-> !bclk_o);
  // R7
  latch_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_no) |-> le_run == 16'(LE_CYC));
  // R8
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> (latch_no && !bclk_o));
  // R8
  ready_after_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_no) |-> in_ready_o);
  // R10
  accept_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o);
endmodule

bind dac_word_tx dac_word_tx_chk #(
  .WORD_W (WORD_W),
  .HI_CYC (HI_CYC),
  .LO_CYC (LO_CYC),
  .GAP_CYC(GAP_CYC),
  .LE_CYC (LE_CYC)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o),
  .bclk_o    (bclk_o),
  .sdata_o   (sdata_o),
  .latch_no  (latch_no)
);

// File: tb/dac_word_tx_lane.sv
module dac_word_tx_lane #(
  parameter int unsigned W       = 16,
  parameter int unsigned HI_MIN  = 8,
  parameter int unsigned LO_MIN  = 8,
  parameter int unsigned PER_MIN = 20,
  parameter int unsigned SET_MIN = 4,
  parameter int unsigned GAP_MIN = 4,
  parameter int unsigned LE_MIN  = 10
) (
  input  logic clk,
  input  logic rst_n,
  output int   checks,
  output int   fails,
  output logic done
);
  localparam int unsigned HI  = (HI_MIN > SET_MIN) ? HI_MIN : SET_MIN;
  localparam int unsigned PL  = (PER_MIN > HI) ? PER_MIN - HI : 1;
  localparam int unsigned LO0 = (LO_MIN > SET_MIN) ? LO_MIN : SET_MIN;
  localparam int unsigned LO  = (LO0 > PL) ? LO0 : PL;
  localparam int unsigned GAP = (GAP_MIN > 0) ? GAP_MIN : 1;
  localparam int unsigned LE  = (LE_MIN > 0) ? LE_MIN : 1;
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};

  logic         valid = 1'b0;
  logic [W-1:0] data  = '0;
  logic         ready, bclk, sdata, latch_n;

  dac_word_tx #(
    .WORD_W(W), .BCLK_HI_MIN(HI_MIN), .BCLK_LO_MIN(LO_MIN), .BCLK_PERIOD_MIN(PER_MIN),
    .SETUP_MIN(SET_MIN), .LATCH_GAP_MIN(GAP_MIN), .LATCH_LOW_MIN(LE_MIN)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(valid), .in_ready_o(ready),
    .in_sample_i(data), .bclk_o(bclk), .sdata_o(sdata), .latch_no(latch_n)
  );

  logic [W-1:0] exp_q[$];
  bit           nz_q[$];

  // receiver model
  logic [W-1:0] rx_sh = '0, rx_word = '0;
  int rx_bits = 0, rx_cnt = 0, rx_evt = 0;
  always @(posedge bclk) begin rx_sh = {rx_sh[W-2:0], sdata}; rx_bits++; end
  always @(negedge latch_n) begin rx_word = rx_sh; rx_cnt = rx_bits; rx_evt++; end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s W=%0d actual=%0h expected=%0h", req, W, act, exp);
    end
  endtask

  // monitor / scoreboard
  bit p_bclk = 0, p_le = 1, p_ready = 0, p_valid = 0, p_sdata = 0, r1_done = 0;
  int hi_run = 0, lo_run = 0, le_run = 0, seen = 0, base = 0;
  initial begin checks = 0; fails = 0; end
  always @(negedge clk) begin
    if (!rst_n) begin
      if (!r1_done) begin
        chk(bclk == 0, "R1", bclk, 0);
        chk(sdata == 0, "R1", sdata, 0);
        chk(latch_n == 1, "R1", latch_n, 1);
        chk(ready == 1, "R1", ready, 1);
        r1_done = 1;
      end
    end else begin
      if (bclk && !p_bclk) begin chk(lo_run >= LO, "R5", lo_run, LO); lo_run = 0; end
      if (!bclk && p_bclk) begin chk(hi_run == HI, "R5", hi_run, HI); hi_run = 0; end
      if (bclk) chk(sdata == p_sdata, "R4", sdata, p_sdata);
      if (!latch_n && p_le) begin chk(lo_run == GAP, "R6", lo_run, GAP); le_run = 0; end
      if (latch_n && !p_le) begin
        chk(le_run == LE, "R7", le_run, LE);
        chk(ready == 1, "R8", ready, 1);
      end
      if (!latch_n) chk(bclk == 0, "R6", bclk, 0);
      if (ready) chk(latch_n && !bclk, "R8", {latch_n, bclk}, 2'b10);
      if (p_ready && p_valid) chk(ready == 0, "R10", ready, 0);
      if (rx_evt != seen) begin
        seen = rx_evt;
        if (exp_q.size() == 0) chk(0, "R2", rx_word, 0);
        else begin
          logic [W-1:0] e;
          bit nz;
          e = exp_q.pop_front();
          nz = nz_q.pop_front();
          chk(rx_word == e, nz ? "R9" : "R2", rx_word, e);
        end
        chk(rx_cnt - base == W, "R3", rx_cnt - base, W);
        base = rx_cnt;
      end
      if (bclk) hi_run++; else lo_run++;
      if (!latch_n) le_run++;
    end
    p_bclk = bclk; p_le = latch_n; p_ready = ready; p_valid = valid; p_sdata = sdata;
  end

  // driver: leaves valid high on return
  task automatic put(input logic [W-1:0] w, input bit nz);
    exp_q.push_back(w);
    nz_q.push_back(nz);
    valid = 1'b1;
    data  = w;
    while (!ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_idle();
    valid = 1'b0;
    while (!ready) @(negedge clk);
  endtask

  initial begin
    logic [31:0] lf;
    done = 1'b0;
    lf = 32'h1d87_2b41;
    wait (rst_n);
    @(negedge clk);
    put('0, 0);  wait_idle();     // R2 zero
    put(MAXP, 0); wait_idle();    // R2 full-scale positive
    put(MINN, 0); wait_idle();    // R2 full-scale negative
    put('1, 0);  wait_idle();
    // R9: garbage offered during a transfer
    put({(W/2){2'b10}}, 1);
    data = ~{(W/2){2'b10}};
    while (latch_n) @(negedge clk);
    valid = 1'b0;
    wait_idle();
    // R10: valid held across back-to-back words
    put(W'(1), 0);
    put(MINN | W'(1), 0);
    put(MAXP ^ W'(5), 0);
    wait_idle();
    for (int i = 0; i < 4; i++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      put(lf[W-1:0], 0);
      wait_idle();
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    done = 1'b1;
  end
endmodule

// File: tb/dac_word_tx_test.sv
module dac_word_tx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int   c16, f16, c18, f18;
  logic d16, d18;
  int   cyc = 0;
  int   wd_fail = 0;

  always @(posedge clk) cyc++;

  dac_word_tx_lane #(
    .W(16), .HI_MIN(8), .LO_MIN(8), .PER_MIN(20), .SET_MIN(4), .GAP_MIN(4), .LE_MIN(10)
  ) u_w16 (.clk(clk), .rst_n(rst_n), .checks(c16), .fails(f16), .done(d16));

  dac_word_tx_lane #(
    .W(18), .HI_MIN(2), .LO_MIN(2), .PER_MIN(7), .SET_MIN(3), .GAP_MIN(1), .LE_MIN(1)
  ) u_w18 (.clk(clk), .rst_n(rst_n), .checks(c18), .fails(f18), .done(d18));

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    while (!(d16 && d18) && cyc < 200000) @(posedge clk);
    if (!(d16 && d18)) begin
      wd_fail = 1;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures",
             c16 + c18 + 1, f16 + f18 + wd_fail);
    $finish;
  end
endmodule